// File: doc/BRIEF.md
# Periodic-Start Pre-Trigger Scheduler

This block sits in front of a decimating converter. It watches an external convert-start pulse and decides in which clock cycle the converter's internal conversion cycle begins. Each conversion lasts a fixed number of clocks, `CONV_LEN`. Its weighting window peaks at the midpoint, and its result is ready at the end. The block can place the external start at one of three points of the conversion: its beginning, its peak or its end.

For the peak and end alignments, the block measures the spacing between consecutive channel-1 starts as a count of clocks. It then launches the next conversion early, so that the predicted start falls at the chosen point. Starts taken while the second channel is selected launch a conversion at once and leave the period tracking untouched. When no usable period is known, the block launches on the start itself. The delay from sampling peak to data ready is half a conversion in every alignment; only the launch instant moves.

Top module: `pretrig_sched`

## Requirements
- R1: After reset the alignment is "beginning" (code 0) and `convStart` is low until a start or a configuration change acts.
- R2: With alignment code 0, every start pulse (either channel) gives a one-cycle `convStart` in the cycle after the clock edge at which `extStart` was sampled high.
- R3: A write with `cfgWrEn` high and `cfgAddr` equal to `MODE_ADDR` (3) loads the alignment code from data bits 7:6; writes to any other address leave the alignment unchanged.
- R4: The period is the number of clock edges between two consecutive channel-1 starts (`chanSel` low); the counter saturates at 2^CNT_W-1.
- R5: With code 1 (peak) and a valid period P, `convStart` rises after the edge P-CONV_LEN/2 edges past the last channel-1 start, and a channel-1 start then launches nothing itself.
- R6: With code 2 (end) and a valid period P, `convStart` rises after the edge P-CONV_LEN edges past the last channel-1 start, and a channel-1 start then launches nothing itself.
- R7: A start taken with `chanSel` high (channel 2) launches `convStart` in the next cycle in every alignment and changes neither the measured period nor the launch schedule.
- R8: In codes 1 and 2, a channel-1 start launches at once, as in R2, when no valid period exists: none measured yet, or the last gap was not longer than CONV_LEN, or the counter saturated.
- R9: Code 3 is reserved and acts exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extStart | input | 1 | External convert-start pulse, one cycle, synchronous |
| chanSel | input | 1 | Channel select: 0 = channel 1, 1 = channel 2 |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | ADDR_W | Configuration register address |
| cfgWrData | input | 2 | Bits 7:6 of the written byte (alignment code) |
| convStart | output | 1 | One-cycle internal conversion-start pulse |

## Verification
Channel-1 start trains at fixed spacing are run in each alignment code. Matching pulse cycles separate the three launch offsets from each other and from the immediate launch. A train whose spacing is at or below the conversion length, and a start that follows a gap long enough to saturate the counter, show the fallback to launching on the start. Channel-2 starts woven between channel-1 starts of a peak-aligned train show that they launch at once and do not disturb the prediction. Writes to a foreign address and the reserved code show the configuration decode.

// File: rtl/ptsched_pkg.sv
package ptsched_pkg;

  typedef enum logic [1:0] {
    ALIGN_BEGIN = 2'd0,
    ALIGN_PEAK  = 2'd1,
    ALIGN_END   = 2'd2,
    ALIGN_RSVD  = 2'd3
  } alignMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic restartCnt;
    logic capturePeriod;
  } dpStrobe_t;

  // index of each early-launch comparator
  localparam int HIT_PEAK = 0;
  localparam int HIT_END  = 1;
  localparam int NUM_HITS = 2;

endpackage

// File: rtl/pt_datapath.sv
module pt_datapath
  import ptsched_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int CONV_LEN = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  output logic                gapOk,
  output logic [NUM_HITS-1:0] alignHit
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam int               HALF_LEN = CONV_LEN / 2;

  logic [CNT_W-1:0] sinceLast;
  logic [CNT_W-1:0] periodReg;

  // clocks elapsed since the last channel-1 start, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceLast <= '0;
    end else if (strobe.restartCnt) begin
      sinceLast <= CNT_W'(1);
    end else if (sinceLast != CNT_MAX) begin
      sinceLast <= sinceLast + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodReg <= '0;
    end else if (strobe.capturePeriod) begin
      periodReg <= sinceLast;
    end
  end

  assign gapOk = (sinceLast > CNT_W'(CONV_LEN)) && (sinceLast != CNT_MAX);

  // one comparator per early-launch offset
  for (genvar g = 0; g < NUM_HITS; g++) begin : gHit
    localparam int SHIFT = (g == HIT_PEAK) ? HALF_LEN : CONV_LEN;
    assign alignHit[g] = (sinceLast == (periodReg - CNT_W'(SHIFT)));
  end

  p_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restartCnt |=> sinceLast == CNT_W'(1));

  p_count_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restartCnt && sinceLast != CNT_MAX) |=> sinceLast == $past(sinceLast) + CNT_W'(1));

  p_saturate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restartCnt && sinceLast == CNT_MAX) |=> $stable(sinceLast));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capturePeriod |=> periodReg == $past(sinceLast));

endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import ptsched_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MODE_ADDR = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extStart,
  input  logic                chanSel,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [7:6]          cfgWrData,
  input  logic                gapOk,
  input  logic [NUM_HITS-1:0] alignHit,
  output dpStrobe_t           strobe,
  output logic                convStart
);

  alignMode_e modeReg;
  logic       havePrev;
  logic       periodValid;

  logic startCh1, startCh2;
  logic schedMode, schedActive, launchHit, fireNext, modeWrite;

  assign modeWrite = cfgWrEn && (cfgAddr == ADDR_W'(MODE_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= ALIGN_BEGIN;
    end else if (modeWrite) begin
      modeReg <= alignMode_e'(cfgWrData);
    end
  end

  always_comb begin
    startCh1    = extStart && !chanSel;
    startCh2    = extStart && chanSel;
    schedMode   = (modeReg == ALIGN_PEAK) || (modeReg == ALIGN_END);
    schedActive = schedMode && periodValid;
    launchHit   = periodValid &&
                  (((modeReg == ALIGN_PEAK) && alignHit[HIT_PEAK]) ||
                   ((modeReg == ALIGN_END)  && alignHit[HIT_END]));
    fireNext    = startCh2 || (startCh1 && !schedActive) || launchHit;
    strobe.restartCnt    = startCh1;
    strobe.capturePeriod = startCh1 && havePrev && gapOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePrev    <= 1'b0;
      periodValid <= 1'b0;
      convStart   <= 1'b0;
    end else begin
      convStart <= fireNext;
      if (startCh1) begin
        havePrev    <= 1'b1;
        periodValid <= havePrev && gapOk;
      end
    end
  end

  p_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (extStart && modeReg == ALIGN_BEGIN) |=> convStart);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    (extStart && modeReg == ALIGN_RSVD) |=> convStart);

  p_cfg_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    modeWrite |=> modeReg == alignMode_e'($past(cfgWrData)));

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !modeWrite |=> $stable(modeReg));

  p_ch2_launch_r7: assert property (@(posedge clk) disable iff (!rstN)
    startCh2 |=> convStart);

  p_ch2_track_r7: assert property (@(posedge clk) disable iff (!rstN)
    startCh2 |=> ($stable(periodValid) && $stable(havePrev)));

  p_fallback_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startCh1 && !periodValid) |=> convStart);

endmodule

// File: rtl/pretrig_sched.sv
module pretrig_sched
  import ptsched_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int CONV_LEN  = 32,
  parameter int ADDR_W    = 4,
  parameter int MODE_ADDR = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extStart,
  input  logic              chanSel,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [7:6]        cfgWrData,
  output logic              convStart
);

  dpStrobe_t           strobe;
  logic                gapOk;
  logic [NUM_HITS-1:0] alignHit;

  pt_ctrl #(
    .ADDR_W   (ADDR_W),
    .MODE_ADDR(MODE_ADDR)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .extStart (extStart),
    .chanSel  (chanSel),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .gapOk    (gapOk),
    .alignHit (alignHit),
    .strobe   (strobe),
    .convStart(convStart)
  );

  pt_datapath #(
    .CNT_W   (CNT_W),
    .CONV_LEN(CONV_LEN)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .gapOk   (gapOk),
    .alignHit(alignHit)
  );

  initial begin
    p_params_r4: assert ((CONV_LEN % 2 == 0) && (CONV_LEN + 1 < (1 << CNT_W)));
  end

endmodule

// File: tb/tb_pretrig_sched.sv
`timescale 1ns/1ps
module tb_pretrig_sched;

  localparam int CNT_W    = 12;
  localparam int CONV_LEN = 32;
  localparam int HALF     = CONV_LEN / 2;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extStart = 1'b0;
  logic       chanSel = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [7:6] cfgWrData = '0;
  logic       convStart;

  pretrig_sched #(.CNT_W(CNT_W), .CONV_LEN(CONV_LEN)) dut (
    .clk(clk), .rstN(rstN), .extStart(extStart), .chanSel(chanSel),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .convStart(convStart)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  string reqTag = "R1";
  int    expQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  int mMode = 0;
  bit mHavePrev = 0;
  bit mValid = 0;
  int mPer = 0;
  int mLast = 0;
  bit pendOn = 0;
  int pendAt = 0;

  task automatic dropExp(int c);
    for (int i = 0; i < expQ.size(); i++) begin
      if (expQ[i] == c) begin
        expQ.delete(i);
        return;
      end
    end
  endtask

  task automatic modelStart(int e, bit ch);
    bit sched;
    int gap;
    bit newValid;
    if (ch) begin
      expQ.push_back(e);
      return;
    end
    if (pendOn && pendAt > e) dropExp(pendAt);
    pendOn = 0;
    sched = (mMode == 1) || (mMode == 2);
    if (!(sched && mValid)) expQ.push_back(e);
    gap = e - mLast;
    newValid = mHavePrev && (gap > CONV_LEN) && (gap < CNT_MAX);
    if (newValid) mPer = gap;
    mValid = newValid;
    mHavePrev = 1;
    mLast = e;
    if (mValid && sched) begin
      pendOn = 1;
      pendAt = e + mPer - ((mMode == 1) ? HALF : CONV_LEN);
      expQ.push_back(pendAt);
    end
  endtask

  task automatic startPulse(bit ch);
    @(negedge clk);
    extStart = 1'b1;
    chanSel  = ch;
    modelStart(cyc + 1, ch);
    @(negedge clk);
    extStart = 1'b0;
    chanSel  = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(int addr, int code);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgAddr   = 4'(addr);
    cfgWrData = 2'(code);
    if (addr == 3) mMode = code;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic train(int period, int n);
    for (int i = 0; i < n; i++) begin
      startPulse(1'b0);
      idle(period - 2);
    end
  endtask

  // monitor: each pulse must match an expected cycle
  always @(negedge clk) begin
    if (rstN && convStart) begin
      int idx;
      idx = -1;
      for (int i = 0; i < expQ.size(); i++) begin
        if (idx < 0 && expQ[i] == cyc) idx = i;
      end
      total++;
      if (idx < 0) begin
        bad++;
        $display("FAIL %s: pulse at cycle %0d, expected cycles %p", reqTag, cyc, expQ);
      end else begin
        expQ.delete(idx);
      end
    end
  end

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    // R1: quiet after reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      total++;
      if (convStart !== 1'b0) begin
        bad++;
        $display("FAIL R1: convStart=%b expected=0", convStart);
      end
    end
    // R1 R2: default alignment launches on each start
    reqTag = "R2";
    train(50, 4);
    // R3: foreign address does not change the alignment
    reqTag = "R3";
    idle(200);
    cfgWrite(2, 2);
    train(50, 3);
    // R5: peak alignment
    reqTag = "R5";
    idle(200);
    cfgWrite(3, 1);
    train(60, 5);
    // R6: end alignment
    reqTag = "R6";
    idle(200);
    cfgWrite(3, 2);
    train(70, 5);
    // R8: spacing at or below the conversion length
    reqTag = "R8";
    train(30, 4);
    train(CONV_LEN, 3);
    // R7: channel-2 starts between peak-aligned channel-1 starts
    reqTag = "R7";
    idle(200);
    cfgWrite(3, 1);
    train(80, 2);
    for (int i = 0; i < 4; i++) begin
      startPulse(1'b0);
      idle(20);
      startPulse(1'b1);
      idle(54);
    end
    // R9: reserved code acts as code 0
    reqTag = "R9";
    idle(200);
    cfgWrite(3, 3);
    train(60, 3);
    // R8 R4: saturated gap leaves no valid period
    reqTag = "R8";
    idle(200);
    cfgWrite(3, 1);
    idle(CNT_MAX + 100);
    train(60, 4);
    idle(200);
    // every expected launch must have appeared
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL %s: missing launches actual=%0d pending expected=0 (%p)", reqTag, expQ.size(), expQ);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule